// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Array with Cluster Steering

This block is the combinational heart of one programmable logic block. Twenty-two input signals feed an array of 68 product terms. Each term is an AND of any chosen inputs, each taken in its true or its complemented form, as set by configuration bits. The first 64 terms are logic terms, grouped four at a time into 16 clusters. The last four are special terms: two output-enable terms, one asynchronous-reset term and one asynchronous-preset term.

A steering stage sends each cluster to one macrocell inside a small sliding window around the cluster's own position. Each of the 16 sum outputs is the OR of the clusters steered to it. So a macrocell can gather up to sixteen terms from neighbouring clusters, and a wide function borrows terms from the cells next to it.

Configuration is held in registers written through a word-wide parallel port. These registers can be loaded only while evaluation is disabled. The path from the inputs to the sums and special terms is purely combinational.

Top module: `ptSumArray`

## Requirements
- R1: After reset, every term is disabled and every steering code is 2, so that cluster c targets macrocell c. `sumOut`, `oeTerm`, `arTerm`, `apTerm` and `cfgFault` are all 0.
- R2: A write with `cfgAddr` k (0 to 67) loads term k as follows: `cfgData[21:0]` are the true-form selects, `cfgData[43:22]` are the complement-form selects, and `cfgData[44]` disables the term. Terms 4c to 4c+3 form cluster c. Terms 64 and 65 are output enables 0 and 1, term 66 is the asynchronous reset and term 67 is the asynchronous preset.
- R3: A term is 1 only when it is enabled, every true-selected input is 1 and every complement-selected input is 0. An enabled term with no selections is 1. A term that selects both forms of one input is 0.
- R4: A write to `cfgAddr` 68 loads the steering codes, with cluster c's code in `cfgData[2c+1:2c]`. Cluster c drives only macrocell c-2+code. `sumOut[m]` is the OR of the clusters that target m, and a cluster steered away from m adds 0 to it.
- R5: Some codes point outside macrocells 0 to 15: cluster 0 with code 0 or 1, cluster 1 with code 0, and cluster 15 with code 3. Any such code sets `cfgFault` to 1, and the cluster concerned then drives no macrocell.
- R6: One macrocell can collect four clusters (sixteen terms). For example, macrocell 5 can collect clusters 4, 5, 6 and 7 with codes 3, 2, 1 and 0.
- R7: Configuration writes are ignored while `evalEn` is 1. Writes to addresses above 68 have no effect.
- R8: `sumOut` and the special terms follow `inVec` with no clock edge in between.
- R9: Terms 64 to 67 drive `oeTerm[0]`, `oeTerm[1]`, `arTerm` and `apTerm` in that order, and they never reach `sumOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evalEn | input | 1 | Evaluation active; blocks configuration writes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Term index 0..67, or 68 for the steering word |
| cfgData | input | 45 | Configuration write data |
| inVec | input | 22 | Array inputs |
| sumOut | output | 16 | Per-macrocell sum of steered clusters |
| oeTerm | output | 2 | Output-enable special terms |
| arTerm | output | 1 | Asynchronous-reset special term |
| apTerm | output | 1 | Asynchronous-preset special term |
| cfgFault | output | 1 | Some cluster is steered outside its window |

## Verification
A wrong steering code or a corrupted term mask appears on `sumOut` in the same cycle as the input pattern that exercises it. Because of this, each directed scenario drives inputs that separate the intended macrocell from its neighbours, and samples right after the inputs settle. A stored write that should have been blocked only shows when a later input pattern reaches the changed term, so the blocked-write tests re-probe the term they tried to change. A wrong window decode shows at once on `cfgFault`, and as a missing sum bit at the edge clusters.

// File: rtl/ptSumPkg.sv
package ptSumPkg;
  parameter int N_IN      = 22;
  parameter int N_CLUST   = 16;
  parameter int CLUST_SZ  = 4;
  parameter int N_SPECIAL = 4;
  parameter int WIN       = 4;
  parameter int WIN_LO    = 2;

  localparam int N_LOGIC = N_CLUST * CLUST_SZ;
  localparam int N_TERM  = N_LOGIC + N_SPECIAL;
  localparam int CFG_W   = 2 * N_IN + 1;
  localparam int ADDR_W  = $clog2(N_TERM + 1);
  localparam int STEER_W = $clog2(WIN);
  localparam int IDX_W   = $clog2(N_TERM);
  localparam int STEER_ADDR = N_TERM;

  typedef struct packed {
    logic             wrTerm;
    logic             wrSteer;
    logic [IDX_W-1:0] termIdx;
  } cfgStrobe_t;
endpackage

// File: rtl/ptSumCtrl.sv
module ptSumCtrl
  import ptSumPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalEn,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfgStrobe_t        stb
);
  logic loadOk;
  assign loadOk = cfgWe && !evalEn;

  always_comb begin
    stb.wrTerm  = loadOk && (cfgAddr < ADDR_W'(N_TERM));
    stb.wrSteer = loadOk && (cfgAddr == ADDR_W'(STEER_ADDR));
    stb.termIdx = cfgAddr[IDX_W-1:0];
  end

  // R7: no strobe may leave while evaluation runs
  p_load_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    evalEn |-> !(stb.wrTerm || stb.wrSteer));

  // R2, R4: one configuration target per write
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrTerm, stb.wrSteer}));
endmodule

// File: rtl/ptSumData.sv
module ptSumData
  import ptSumPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           stb,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [N_IN-1:0]      inVec,
  output logic [N_CLUST-1:0]   sumOut,
  output logic [1:0]           oeTerm,
  output logic                 arTerm,
  output logic                 apTerm,
  output logic                 cfgFault
);
  logic [N_TERM-1:0][N_IN-1:0]     trueSel;
  logic [N_TERM-1:0][N_IN-1:0]     compSel;
  logic [N_TERM-1:0]               termDis;
  logic [N_CLUST-1:0][STEER_W-1:0] steer;
  logic [N_TERM-1:0]               termVal;
  logic [N_CLUST-1:0]              clustOr;
  logic [N_CLUST-1:0]              badSteer;
  logic [N_CLUST-1:0][WIN-1:0]     hit;

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trueSel <= '0;
      compSel <= '0;
      termDis <= '1;
      for (int c = 0; c < N_CLUST; c++) steer[c] <= STEER_W'(WIN_LO);
    end else begin
      if (stb.wrTerm) begin
        trueSel[stb.termIdx] <= cfgData[N_IN-1:0];
        compSel[stb.termIdx] <= cfgData[2*N_IN-1:N_IN];
        termDis[stb.termIdx] <= cfgData[2*N_IN];
      end
      if (stb.wrSteer) steer <= cfgData[N_CLUST*STEER_W-1:0];
    end
  end

  // AND array: a selected literal that is false kills the term
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign termVal[t] = !termDis[t] &&
                        ((trueSel[t] & ~inVec) == '0) &&
                        ((compSel[t] &  inVec) == '0);
  end

  for (genvar c = 0; c < N_CLUST; c++) begin : g_clust
    assign clustOr[c] = |termVal[c*CLUST_SZ +: CLUST_SZ];
    always_comb begin
      int tgt;
      tgt = c - WIN_LO + int'(steer[c]);
      badSteer[c] = (tgt < 0) || (tgt >= N_CLUST);
    end
  end

  // steering: macrocell m looks at the clusters whose window covers it
  for (genvar m = 0; m < N_CLUST; m++) begin : g_mc
    for (genvar s = 0; s < WIN; s++) begin : g_slot
      localparam int SRC = m + WIN_LO - s;
      if (SRC >= 0 && SRC < N_CLUST) begin : g_live
        assign hit[m][s] = (steer[SRC] == STEER_W'(s)) && clustOr[SRC];
      end else begin : g_dead
        assign hit[m][s] = 1'b0;
      end
    end
    assign sumOut[m] = |hit[m];
  end

  assign cfgFault = |badSteer;
  assign oeTerm   = termVal[N_LOGIC +: 2];
  assign arTerm   = termVal[N_LOGIC + 2];
  assign apTerm   = termVal[N_LOGIC + 3];

  // R4: a cluster feeds at most one macrocell
  p_fanout_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sumOut) <= $countones(clustOr));

  // R7: configuration holds across a cycle with no strobe
  p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrTerm || stb.wrSteer) |=> ($stable(steer) && $stable(termDis)
                                      && $stable(trueSel) && $stable(compSel)));

  // R3, R9: a disabled reset term never asserts
  p_dis_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    termDis[N_LOGIC + 2] |-> !arTerm);

  // R5: no fault means every active sum has a source in range
  p_fault_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgFault && (clustOr == '0)) |-> (sumOut == '0));
endmodule

// File: rtl/ptSumArray.sv
module ptSumArray
  import ptSumPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalEn,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [N_IN-1:0]   inVec,
  output logic [N_CLUST-1:0] sumOut,
  output logic [1:0]        oeTerm,
  output logic              arTerm,
  output logic              apTerm,
  output logic              cfgFault
);
  cfgStrobe_t stb;

  ptSumCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .evalEn(evalEn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .stb(stb)
  );

  ptSumData i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgData(cfgData), .inVec(inVec),
    .sumOut(sumOut), .oeTerm(oeTerm), .arTerm(arTerm), .apTerm(apTerm),
    .cfgFault(cfgFault)
  );
endmodule

// File: tb/test_ptSumArray.sv
module test_ptSumArray;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [44:0] cfgData = '0;
  logic [21:0] inVec = '0;
  logic [15:0] sumOut;
  logic [1:0]  oeTerm;
  logic        arTerm, apTerm, cfgFault;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptSumArray i_ptSumArray (
    .clk(clk), .rstN(rstN), .evalEn(evalEn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .inVec(inVec),
    .sumOut(sumOut), .oeTerm(oeTerm), .arTerm(arTerm), .apTerm(apTerm),
    .cfgFault(cfgFault)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input logic [44:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 7'(addr); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [44:0] row(input logic dis, input logic [21:0] c, input logic [21:0] t);
    return {dis, c, t};
  endfunction

  task automatic drive(input logic [21:0] v);
    inVec = v;
    #1;
  endtask

  task automatic t_reset;
    drive(22'h3FFFFF);
    check("R1 sum", 32'(sumOut), 0);
    check("R1 oe", 32'(oeTerm), 0);
    check("R1 ar/ap", 32'({arTerm, apTerm}), 0);
    check("R1 fault", 32'(cfgFault), 0);
  endtask

  task automatic t_terms;
    cfgWrite(0, row(1'b0, 22'h2, 22'h1));
    cfgWrite(5, row(1'b0, 22'h0, 22'h0));
    cfgWrite(8, row(1'b0, 22'h8, 22'h8));
    drive(22'h1);
    check("R3 true/comp match", 32'(sumOut), 32'h0003);
    drive(22'h0);
    check("R8 comb follow", 32'(sumOut), 32'h0002);
    drive(22'h3);
    check("R3 comp violated", 32'(sumOut), 32'h0002);
    drive(22'h8);
    check("R3 conflict term", 32'(sumOut[2]), 0);
  endtask

  task automatic t_steer;
    cfgWrite(68, 45'hAAAAAAAE);
    drive(22'h0);
    check("R4 c1 moved to M2", 32'(sumOut), 32'h0004);
  endtask

  task automatic t_gather;
    cfgWrite(0, row(1'b1, 0, 0));
    cfgWrite(5, row(1'b1, 0, 0));
    cfgWrite(8, row(1'b1, 0, 0));
    cfgWrite(16, row(1'b0, 0, 22'h10));
    cfgWrite(21, row(1'b0, 0, 22'h20));
    cfgWrite(26, row(1'b0, 0, 22'h40));
    cfgWrite(31, row(1'b0, 0, 22'h80));
    cfgWrite(68, 45'hAAAA1BAA);
    drive(22'h10);
    check("R6 c4 to M5", 32'(sumOut), 32'h0020);
    drive(22'h80);
    check("R6 c7 to M5", 32'(sumOut), 32'h0020);
    drive(22'hF0);
    check("R6 all four", 32'(sumOut), 32'h0020);
    drive(22'h0);
    check("R6 none", 32'(sumOut), 0);
  endtask

  task automatic t_window;
    cfgWrite(1, row(1'b0, 0, 0));
    cfgWrite(68, 45'hAAAA1BA8);
    drive(22'h0);
    check("R5 c0 code0 fault", 32'(cfgFault), 1);
    check("R5 c0 feeds none", 32'(sumOut), 0);
    cfgWrite(68, 45'hAAAA1BAA);
    check("R5 legal clears", 32'(cfgFault), 0);
    check("R5 c0 back on M0", 32'(sumOut), 32'h0001);
    cfgWrite(68, 45'hEAAA1BAA);
    check("R5 c15 code3 fault", 32'(cfgFault), 1);
    cfgWrite(68, 45'hAAAA1BA2);
    check("R5 c1 code0 fault", 32'(cfgFault), 1);
    cfgWrite(68, 45'hAAAA1BAA);
  endtask

  task automatic t_locked;
    @(negedge clk); evalEn = 1'b1;
    cfgWrite(1, row(1'b1, 0, 0));
    cfgWrite(68, 45'h55555555);
    drive(22'h0);
    check("R7 term write blocked", 32'(sumOut), 32'h0001);
    check("R7 steer write blocked", 32'(cfgFault), 0);
    @(negedge clk); evalEn = 1'b0;
    cfgWrite(69, 45'h0);
    cfgWrite(127, 45'h0);
    drive(22'h10);
    check("R7 high address ignored", 32'(sumOut), 32'h0021);
  endtask

  task automatic t_special;
    cfgWrite(64, row(1'b0, 0, 0));
    cfgWrite(66, row(1'b0, 0, 22'h400));
    cfgWrite(67, row(1'b0, 22'h400, 0));
    drive(22'h400);
    check("R9 oe", 32'(oeTerm), 32'h1);
    check("R9 ar/ap high", 32'({arTerm, apTerm}), 32'h2);
    check("R9 sum untouched", 32'(sumOut), 32'h0001);
    drive(22'h0);
    check("R9 ar/ap low", 32'({arTerm, apTerm}), 32'h1);
    check("R2 term65 still off", 32'(oeTerm[1]), 0);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_terms();
    t_steer();
    t_gather();
    t_window();
    t_locked();
    t_special();
    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule